// File: doc/BRIEF.md
# Clock Prescaler and Gating Unit

This unit produces single-cycle clock-enable strobes for a small system-on-chip. It runs on the fast PLL-derived clock, which is seven times a 14.7456 MHz crystal, about 103.22 MHz. Two qualifier inputs stand in for the other two reference sources. `xtal_tick` marks the edges of the crystal domain. `slow_tick` marks the edges of the 32.768 kHz low-speed oscillator.

A programmable divider makes the system/CPU strobe from the fast clock. Two more programmable prescalers count system strobes: one feeds the synchronous serial port and one feeds the display controller. A fixed 15-bit wrap counter divides `slow_tick` by 32768 to give a 1 Hz real-time-clock tick. The UART strobe is taken straight from the crystal domain. Each derived strobe has its own enable bit. The enable bits are spread over a bus-clock register and two peripheral-clock registers, all written through a simple write port.

Top module: `clk_prescale_gate`

## Requirements
- R1: After reset every enable bit and every prescaler register is zero. The system strobe is then high on every cycle, and all the other strobes are low.
- R2: `sys_ce` pulses once every N cycles, where N is bits [7:0] of the register at address 0. N = 0 divides by one.
- R3: `dma_ce` equals `sys_ce` while bit 0 of the register at address 1 is set. It is low otherwise, and that bit is clear after reset.
- R4: A new prescaler value written while a divider is running takes effect only after that divider's next strobe. The period in progress always completes at its old length.
- R5: `ssp_ce` is enabled by bit 0 of address 3. It divides the `sys_ce` strobes by the value in bits [7:0] of address 4, with 0 meaning one.
- R6: `lcd_ce` is enabled by bit 1 of address 3. It divides the `sys_ce` strobes by the value in bits [7:0] of address 5, with 0 meaning one.
- R7: `uart_ce` equals `xtal_tick` while bit 1 of address 2 is set, and is low otherwise.
- R8: While bit 0 of address 2 is set, a 15-bit counter advances on each `slow_tick`. `rtc_ce` pulses on the tick that wraps the counter from 32767 to 0, so there is exactly one pulse per 32768 ticks.
- R9: Clearing an enable forces its strobe low and holds its counter at zero. After the enable is set again, the first strobe comes only after a full period.
- R10: Writes to addresses 6 and 7 change no register and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PLL-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| xtal_tick | input | 1 | Edge marker of the crystal domain |
| slow_tick | input | 1 | Edge marker of the 32.768 kHz domain |
| sys_ce | output | 1 | System/CPU clock enable |
| dma_ce | output | 1 | DMA clock enable |
| ssp_ce | output | 1 | Serial port clock enable |
| lcd_ce | output | 1 | Display clock enable |
| uart_ce | output | 1 | UART clock enable |
| rtc_ce | output | 1 | 1 Hz real-time-clock tick |

## Verification
The hardest cases to reach are a prescaler rewrite that lands in the middle of a period and the wrap of the 1 Hz counter. The stimulus rewrites the system, serial and display dividers while their counters are partway through a count. It also enables and disables the peripherals between such writes, and a reference model predicts every strobe on every cycle. To reach the slow wrap, the bench holds `slow_tick` high for two full 32768-tick periods and counts the resulting pulses. Writes of all ones to the unused addresses are checked against unchanged strobes.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SYSDIV = 3'd0,
    A_BUSEN  = 3'd1,
    A_PERA   = 3'd2,
    A_PERB   = 3'd3,
    A_SSPDIV = 3'd4,
    A_LCDDIV = 3'd5
  } cpg_addr_e;

  typedef struct packed {
    logic dma;
    logic rtc;
    logic uart;
    logic ssp;
    logic lcd;
  } cpg_en_t;
endpackage

// File: rtl/cpg_regs.sv
module cpg_regs
  import cpg_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DW-1:0]     sys_div,
  output logic [DW-1:0]     ssp_div,
  output logic [DW-1:0]     lcd_div,
  output cpg_en_t           en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_div <= '0;
      ssp_div <= '0;
      lcd_div <= '0;
      en      <= '0;
    end else if (wr_en) begin
      case (cpg_addr_e'(wr_addr))
        A_SYSDIV: sys_div <= wr_data[DW-1:0];
        A_BUSEN:  en.dma  <= wr_data[0];
        A_PERA: begin
          en.rtc  <= wr_data[0];
          en.uart <= wr_data[1];
        end
        A_PERB: begin
          en.ssp <= wr_data[0];
          en.lcd <= wr_data[1];
        end
        A_SSPDIV: ssp_div <= wr_data[DW-1:0];
        A_LCDDIV: lcd_div <= wr_data[DW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpg_divider.sv
module cpg_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         adv,
  input  logic [W-1:0] div_in,
  output logic         strobe,
  output logic         at_term
);
  logic [W-1:0] cnt;
  logic [W-1:0] cur;

  // Last count of a period: a divisor of 0 behaves as 1.
  function automatic logic [W-1:0] last_count(input logic [W-1:0] n);
    return (n == '0) ? '0 : n - W'(1);
  endfunction

  assign at_term = (cnt == last_count(cur));
  assign strobe  = run & adv & at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cur <= '0;
    end else if (!run) begin
      cnt <= '0;
      cur <= div_in;
    end else if (adv) begin
      if (at_term) begin
        cnt <= '0;
        cur <= div_in;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end
endmodule

// File: rtl/cpg_wrap_tick.sv
module cpg_wrap_tick #(
  parameter int CW = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic adv,
  output logic strobe
);
  logic [CW-1:0] cnt;

  assign strobe = run & adv & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (adv)     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/clk_prescale_gate.sv
module clk_prescale_gate
  import cpg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DATA_W   = 16,
  parameter int RTC_BITS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xtal_tick,
  input  logic              slow_tick,
  output logic              sys_ce,
  output logic              dma_ce,
  output logic              ssp_ce,
  output logic              lcd_ce,
  output logic              uart_ce,
  output logic              rtc_ce
);
  logic [DW-1:0] sys_div, ssp_div, lcd_div;
  cpg_en_t       en;

  // Named internal events for the checker
  logic ssp_run, lcd_run, rtc_run, uart_run, dma_run;
  logic sys_term, ssp_term, lcd_term;

  cpg_regs #(.DW(DW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sys_div(sys_div), .ssp_div(ssp_div),
    .lcd_div(lcd_div), .en(en)
  );

  assign ssp_run  = en.ssp;
  assign lcd_run  = en.lcd;
  assign rtc_run  = en.rtc;
  assign uart_run = en.uart;
  assign dma_run  = en.dma;

  cpg_divider #(.W(DW)) u_sys (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .adv(1'b1),
    .div_in(sys_div), .strobe(sys_ce), .at_term(sys_term)
  );

  cpg_divider #(.W(DW)) u_ssp (
    .clk(clk), .rst_n(rst_n), .run(ssp_run), .adv(sys_ce),
    .div_in(ssp_div), .strobe(ssp_ce), .at_term(ssp_term)
  );

  cpg_divider #(.W(DW)) u_lcd (
    .clk(clk), .rst_n(rst_n), .run(lcd_run), .adv(sys_ce),
    .div_in(lcd_div), .strobe(lcd_ce), .at_term(lcd_term)
  );

  cpg_wrap_tick #(.CW(RTC_BITS)) u_rtc (
    .clk(clk), .rst_n(rst_n), .run(rtc_run), .adv(slow_tick),
    .strobe(rtc_ce)
  );

  assign dma_ce  = sys_ce & dma_run;
  assign uart_ce = xtal_tick & uart_run;
endmodule

// File: rtl/cpg_chk.sv
module cpg_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_ce,
  input logic dma_ce,
  input logic ssp_ce,
  input logic lcd_ce,
  input logic uart_ce,
  input logic rtc_ce,
  input logic xtal_tick,
  input logic slow_tick,
  input logic ssp_run,
  input logic lcd_run,
  input logic rtc_run,
  input logic uart_run
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !(dma_ce || ssp_ce || lcd_ce || uart_ce || rtc_ce));

  a_r3_dma_follows_sys: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ce |-> sys_ce);

  a_r5_ssp_on_sys: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_ce |-> sys_ce);

  a_r6_lcd_on_sys: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_ce |-> sys_ce);

  a_r7_uart_from_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    uart_ce |-> (xtal_tick && uart_run));

  a_r8_rtc_on_slow: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_ce |-> (slow_tick && rtc_run));

  a_r9_ssp_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ssp_run |-> !ssp_ce);

  a_r9_lcd_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_run |-> !lcd_ce);
endmodule

bind clk_prescale_gate cpg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .dma_ce(dma_ce),
  .ssp_ce(ssp_ce), .lcd_ce(lcd_ce), .uart_ce(uart_ce), .rtc_ce(rtc_ce),
  .xtal_tick(xtal_tick), .slow_tick(slow_tick), .ssp_run(ssp_run),
  .lcd_run(lcd_run), .rtc_run(rtc_run), .uart_run(uart_run)
);

// File: tb/sim_clk_prescale_gate.sv
module sim_clk_prescale_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        xtal_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic sys_ce, dma_ce, ssp_ce, lcd_ce, uart_ce, rtc_ce;

  always #2 clk = ~clk;

  clk_prescale_gate u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xtal_tick(xtal_tick), .slow_tick(slow_tick),
    .sys_ce(sys_ce), .dma_ce(dma_ce), .ssp_ce(ssp_ce), .lcd_ce(lcd_ce),
    .uart_ce(uart_ce), .rtc_ce(rtc_ce)
  );

  int n_chk = 0, n_err = 0, cyc_n = 0, slow_mode = 0, rtc_seen = 0;
  bit finished = 0;

  // Reference model state
  int m_sysdiv = 0, m_sspdiv = 0, m_lcddiv = 0;
  bit m_dma = 0, m_rtc = 0, m_uart = 0, m_ssp = 0, m_lcd = 0;
  int s_cnt = 0, s_cur = 0, p_cnt = 0, p_cur = 0, l_cnt = 0, l_cur = 0, r_cnt = 0;

  function automatic int period_end(int v);
    return (v < 2) ? 0 : v - 1;
  endfunction

  task automatic check(string tag, logic act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic tick(bit we, int a, int d);
    bit e_sys, e_dma, e_ssp, e_lcd, e_uart, e_rtc;
    @(negedge clk);
    rst_n     = 1'b1;
    wr_en     = we;
    wr_addr   = a[2:0];
    wr_data   = d[15:0];
    xtal_tick = (cyc_n % 8 == 3);
    slow_tick = (slow_mode == 1) ? 1'b1 : (slow_mode == 2) ? (cyc_n % 3 == 0) : 1'b0;
    #1;
    e_sys  = (s_cnt == period_end(s_cur));
    e_dma  = e_sys && m_dma;
    e_ssp  = m_ssp && e_sys && (p_cnt == period_end(p_cur));
    e_lcd  = m_lcd && e_sys && (l_cnt == period_end(l_cur));
    e_uart = m_uart && xtal_tick;
    e_rtc  = m_rtc && slow_tick && (r_cnt == 32767);
    check("R2 R4 sys_ce", sys_ce, e_sys);
    check("R3 dma_ce", dma_ce, e_dma);
    check("R5 R9 ssp_ce", ssp_ce, e_ssp);
    check("R6 R9 lcd_ce", lcd_ce, e_lcd);
    check("R7 uart_ce", uart_ce, e_uart);
    check("R8 rtc_ce", rtc_ce, e_rtc);
    if (rtc_ce === 1'b1) rtc_seen++;
    // counters see the register values from before this edge
    if (e_sys) begin s_cnt = 0; s_cur = m_sysdiv; end else s_cnt++;
    if (!m_ssp) begin p_cnt = 0; p_cur = m_sspdiv; end
    else if (e_sys) begin
      if (p_cnt == period_end(p_cur)) begin p_cnt = 0; p_cur = m_sspdiv; end else p_cnt++;
    end
    if (!m_lcd) begin l_cnt = 0; l_cur = m_lcddiv; end
    else if (e_sys) begin
      if (l_cnt == period_end(l_cur)) begin l_cnt = 0; l_cur = m_lcddiv; end else l_cnt++;
    end
    if (!m_rtc) r_cnt = 0; else if (slow_tick) r_cnt = (r_cnt + 1) % 32768;
    if (we) begin
      case (a)
        0: m_sysdiv = d & 255;
        1: m_dma = d[0];
        2: begin m_rtc = d[0]; m_uart = d[1]; end
        3: begin m_ssp = d[0]; m_lcd = d[1]; end
        4: m_sspdiv = d & 255;
        5: m_lcddiv = d & 255;
        default: ;
      endcase
    end
    cyc_n++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tick(0, 0, 0);
    // R1: directly after reset the system strobe runs, the others are quiet
    check("R1 sys_ce after reset", sys_ce, 1'b1);
    check("R1 quiet after reset", dma_ce | ssp_ce | lcd_ce | uart_ce | rtc_ce, 1'b0);
    idle(10);
    // R2 / R4: system divider, rewritten mid-period
    tick(1, 0, 3); idle(13);
    tick(1, 0, 5); idle(30);
    tick(1, 0, 16'hFF02); idle(20);
    // R3: DMA enable on and off
    tick(1, 1, 1); idle(20);
    tick(1, 1, 0); idle(8);
    // R5 / R6: serial and display prescalers
    tick(1, 4, 2); tick(1, 5, 0);
    tick(1, 3, 3); idle(37);
    tick(1, 4, 4); tick(1, 5, 3); idle(60);
    // R7: UART from the crystal ticks
    tick(1, 2, 2); idle(50);
    // R10: unused addresses
    tick(1, 6, 16'hFFFF); tick(1, 7, 16'hFFFF); idle(40);
    // R9: disable serial port, then re-enable
    tick(1, 3, 2); idle(25);
    tick(1, 3, 3); idle(40);
    // R8: slow ticks in bursts, then two full RTC periods
    slow_mode = 2; tick(1, 2, 1); idle(100);
    tick(1, 2, 0); idle(5);
    slow_mode = 1; tick(1, 0, 1); tick(1, 2, 1);
    rtc_seen = 0;
    idle(2 * 32768 + 10);
    n_chk++;
    if (rtc_seen != 2) begin
      n_err++;
      $display("FAIL R8 pulse count: actual %0d expected 2", rtc_seen);
    end
    slow_mode = 0; idle(10);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule